// File: doc/BRIEF.md
# Instruction Word Decode Status Unit

This unit performs the first decode step on a newly fetched instruction word. The word comes from the adder output latch. A single-cycle command pulse latches the word into two working registers. The same pulse extracts two 4-bit fields: one into a register-select register and one into a digit counter. It also updates a group of status flags and produces a 2-bit code giving the instruction length.

Bits are numbered from the most significant end. Word bit 0 is port bit 31, and word bit 31 is port bit 0. Every update triggered by the command takes effect on a single clock edge. When the command is low, all state holds, except for the one external request that raises the refetch flag.

The unit sits inside a microprogrammed sequencer. The sequencer issues the command once per instruction, right after the fetch. Later steps then read the captured fields and flags.

Top module: `insn_decode_stat`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register, every flag and `len_code` become zero on that edge.
- R2: At an edge with `decode_go` high, `work_a` and `work_b` both take the full value of `latch_word`.
- R3: At an edge with `decode_go` high, `reg_sel` takes word bits 12..15, which are port bits [19:16]. Word bit 12 becomes `reg_sel[3]`.
- R4: At an edge with `decode_go` high, `digit_cnt` takes word bits 16..19, which are port bits [15:12]. Word bit 16 becomes `digit_cnt[3]`.
- R5: At an edge with `decode_go` high, `refetch` is cleared. This holds even if `set_refetch` is high on the same edge. At an edge with `set_refetch` high and `decode_go` low, `refetch` is set to 1.
- R6: At an edge with `decode_go` high, `st_sel_zero` is set to 1 if port bits [19:16] are all zero, and cleared to 0 otherwise.
- R7: At an edge with `decode_go` high, `st_cnt_zero` is set to 1 if port bits [15:12] are all zero, and cleared to 0 otherwise.
- R8: At an edge with `decode_go` high, `st_short` is set to 1 if port bits [15:14] are both zero, and cleared to 0 otherwise.
- R9: At an edge with `decode_go` high, `len_code` is derived from port bits [31:30] as follows:
  - 2'b00 gives 2'b01.
  - 2'b01 or 2'b10 gives 2'b10.
  - 2'b11 gives 2'b11.
- R10: At an edge with `decode_go` low, all outputs except `refetch` keep their values, whatever `latch_word` holds. With `set_refetch` also low, `refetch` keeps its value as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| decode_go | input | 1 | Decode command, one cycle per instruction |
| set_refetch | input | 1 | Request to raise the refetch flag |
| latch_word | input | 32 | Adder latch word holding the fetched instruction |
| work_a | output | 32 | First working copy of the word |
| work_b | output | 32 | Second working copy of the word |
| reg_sel | output | 4 | Register-select field, word bits 12..15 |
| digit_cnt | output | 4 | Digit counter, word bits 16..19 |
| st_sel_zero | output | 1 | Status: register-select field was zero |
| st_cnt_zero | output | 1 | Status: digit field was zero |
| st_short | output | 1 | Status: word bits 16 and 17 were both zero |
| refetch | output | 1 | Refetch flag |
| len_code | output | 2 | Instruction length code |

## Verification
Every piece of state in this unit is an output, so a wrong value appears at the ports one edge after the decode that produced it. The exception is an error that only breaks the hold behaviour. That shows up only on a later idle cycle with a changed latch word, so the bench changes the word between decodes.

Errors in bit order or field placement are caught by sweeping both nibbles and the top two bits through all their values. During the sweep the surrounding bits carry varying contents, so a field read from the wrong position gives the wrong value.

// File: rtl/insn_decode_stat.sv
module insn_decode_stat (
  input  logic        clk,
  input  logic        rst,
  input  logic        decode_go,
  input  logic        set_refetch,
  input  logic [31:0] latch_word,
  output logic [31:0] work_a,
  output logic [31:0] work_b,
  output logic [3:0]  reg_sel,
  output logic [3:0]  digit_cnt,
  output logic        st_sel_zero,
  output logic        st_cnt_zero,
  output logic        st_short,
  output logic        refetch,
  output logic [1:0]  len_code
);

  // word bit n (bit 0 = MSB) sits at port bit 31-n
  logic [1:0] op_top;
  logic [3:0] sel_fld;
  logic [3:0] cnt_fld;
  logic [1:0] len_next;

  assign op_top  = latch_word[31:30];
  assign sel_fld = latch_word[19:16];
  assign cnt_fld = latch_word[15:12];

  always_comb begin
    case (op_top)
      2'b00:   len_next = 2'b01;
      2'b11:   len_next = 2'b11;
      default: len_next = 2'b10;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work_a      <= '0;
      work_b      <= '0;
      reg_sel     <= '0;
      digit_cnt   <= '0;
      st_sel_zero <= 1'b0;
      st_cnt_zero <= 1'b0;
      st_short    <= 1'b0;
      refetch     <= 1'b0;
      len_code    <= 2'b00;
    end else if (decode_go) begin
      work_a      <= latch_word;
      work_b      <= latch_word;
      reg_sel     <= sel_fld;
      digit_cnt   <= cnt_fld;
      st_sel_zero <= (sel_fld == 4'd0);
      st_cnt_zero <= (cnt_fld == 4'd0);
      st_short    <= (cnt_fld[3:2] == 2'b00);
      refetch     <= 1'b0;
      len_code    <= len_next;
    end else if (set_refetch) begin
      refetch     <= 1'b1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (work_a == '0 && work_b == '0 && reg_sel == '0 && digit_cnt == '0
             && !st_sel_zero && !st_cnt_zero && !st_short && !refetch && len_code == 2'b00)); // R1

  AST_COPIES_MATCH: assert property (@(posedge clk) disable iff (rst)
    decode_go |=> (work_a == work_b)); // R2

  AST_SEL_FLAG_AGREES: assert property (@(posedge clk) disable iff (rst)
    decode_go |=> (st_sel_zero == (reg_sel == 4'd0))); // R6

  AST_CNT_FLAG_AGREES: assert property (@(posedge clk) disable iff (rst)
    decode_go |=> (st_cnt_zero == (digit_cnt == 4'd0))); // R7

  AST_SHORT_AGREES: assert property (@(posedge clk) disable iff (rst)
    decode_go |=> (st_short == (digit_cnt[3:2] == 2'b00))); // R8

  AST_REFETCH_CLEARED: assert property (@(posedge clk) disable iff (rst)
    decode_go |=> !refetch); // R5

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    decode_go |=> (len_code != 2'b00)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !decode_go |=> ($stable(work_a) && $stable(reg_sel) && $stable(digit_cnt)
                    && $stable(len_code) && $stable(st_short))); // R10

endmodule

// File: tb/insn_decode_stat_bench.sv
module insn_decode_stat_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        decode_go = 1'b0;
  logic        set_refetch = 1'b0;
  logic [31:0] latch_word = '0;
  logic [31:0] work_a, work_b;
  logic [3:0]  reg_sel, digit_cnt;
  logic        st_sel_zero, st_cnt_zero, st_short, refetch;
  logic [1:0]  len_code;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_decode_stat u_insn_decode_stat (
    .clk(clk), .rst(rst), .decode_go(decode_go), .set_refetch(set_refetch),
    .latch_word(latch_word), .work_a(work_a), .work_b(work_b),
    .reg_sel(reg_sel), .digit_cnt(digit_cnt), .st_sel_zero(st_sel_zero),
    .st_cnt_zero(st_cnt_zero), .st_short(st_short), .refetch(refetch),
    .len_code(len_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic go, input logic setr, input logic [31:0] w);
    @(negedge clk);
    decode_go   = go;
    set_refetch = setr;
    latch_word  = w;
    @(posedge clk);
    #1;
  endtask

  task automatic check_decode(input logic [31:0] w);
    logic [1:0] t;
    logic [3:0] a, b;
    logic [1:0] el;
    t = w[31:30]; a = w[19:16]; b = w[15:12];
    el = (t == 2'd0) ? 2'b01 : (t == 2'd3) ? 2'b11 : 2'b10;
    chk("R2 work_a", work_a, w);
    chk("R2 work_b", work_b, w);
    chk("R3 reg_sel", {28'd0, reg_sel}, {28'd0, a});
    chk("R4 digit_cnt", {28'd0, digit_cnt}, {28'd0, b});
    chk("R6 st_sel_zero", {31'd0, st_sel_zero}, {31'd0, a == 4'd0});
    chk("R7 st_cnt_zero", {31'd0, st_cnt_zero}, {31'd0, b == 4'd0});
    chk("R8 st_short", {31'd0, st_short}, {31'd0, b < 4'd4});
    chk("R9 len_code", {30'd0, len_code}, {30'd0, el});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [31:0] fill;
    fill = 32'h9e37_79b9;
    // R1: reset state, with the command and a word present during reset
    step(1'b1, 1'b1, 32'hffff_ffff);
    chk("R1 work_a", work_a, 32'd0);
    chk("R1 work_b", work_b, 32'd0);
    chk("R1 fields", {24'd0, reg_sel, digit_cnt}, 32'd0);
    chk("R1 flags", {28'd0, st_sel_zero, st_cnt_zero, st_short, refetch}, 32'd0);
    chk("R1 len_code", {30'd0, len_code}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R2..R4, R6..R9 sweep: top bits x both nibbles, with varying filler bits
    for (int t = 0; t < 4; t++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          fill = fill * 32'd1664525 + 32'd1013904223;
          w = {t[1:0], fill[29:20], a[3:0], b[3:0], fill[11:0]};
          step(1'b1, 1'b0, w);
          check_decode(w);
          // R10: idle cycle with a different word must not disturb state
          step(1'b0, 1'b0, ~w);
          check_decode(w);
          chk("R10 refetch hold", {31'd0, refetch}, 32'd0);
        end
      end
    end

    // R5: set request raises the flag, decode clears it, decode wins over a set
    step(1'b0, 1'b1, 32'h1234_5678);
    chk("R5 refetch set", {31'd0, refetch}, 32'd1);
    step(1'b0, 1'b0, 32'h0);
    chk("R5 R10 refetch held", {31'd0, refetch}, 32'd1);
    step(1'b1, 1'b0, 32'h4001_0000);
    chk("R5 refetch cleared", {31'd0, refetch}, 32'd0);
    step(1'b0, 1'b1, 32'h0);
    chk("R5 refetch set again", {31'd0, refetch}, 32'd1);
    step(1'b1, 1'b1, 32'hc00f_3000);
    chk("R5 decode beats set", {31'd0, refetch}, 32'd0);
    check_decode(32'hc00f_3000);

    // R1: reset from a non-zero state
    step(1'b0, 1'b1, 32'h0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 second reset", {work_a[3:0], reg_sel, digit_cnt, 8'd0, st_sel_zero, st_cnt_zero,
        st_short, refetch, len_code, 6'd0}, 32'd0);
    @(negedge clk); rst = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule